// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Unit

This unit turns acknowledge queries into 8-bit vector numbers for a set of interrupt request lines. Each source index has a fixed priority level from 1 to 7 and a fixed rank inside that level. Two kinds of question can be asked. A level query names one level and gets back the vector of the best active source at that level, or a fixed spurious vector if that level is idle. A software query gets back the vector of the best pending source across all levels, or zero if no source is pending.

Queries arrive on two paths that share one lookup. The first is a byte read on a memory-mapped read port. The second is a processor acknowledge cycle that carries a level, and it is honoured only while the acknowledge-enable input is high. Answers are registered and appear one clock after the strobe, together with a one-cycle valid. The unit never changes the request lines. A source stays pending until the peripheral drops it.

Top module: `iack_vector_unit`

## Requirements
- R1: While and right after reset, rdata_o and ack_vec_o are 0x00, and rvalid_o and ack_valid_o are low.
- R2: Source i belongs to level (i mod 7) + 1, and its vector number is 64 + i.
- R3: A read at offset 0x20 + 4*n, for n from 1 to 7, returns the vector of the lowest-indexed active source at level n. Sources at other levels are ignored.
- R4: A level read for a level that has no active source returns 0x18.
- R5: A read at offset 0x20 returns the vector of the active source at the highest level. Within that level, the lowest index wins.
- R6: A read at offset 0x20 returns 0x00 when no source is active.
- R7: A read at any other offset returns 0x00. This covers non-multiples of four, offsets below 0x20 and offsets above 0x3C.
- R8: The data of a read appears on rdata_o in the clock after rd_en_i, with rvalid_o high for that one cycle. In any cycle without a read, rvalid_o is low and rdata_o holds its value.
- R9: When cpu_ack_i and ack_en_i are both high, ack_vec_o takes the level-n answer for cpu_ack_lvl_i one clock later and ack_valid_o pulses. Level 0 returns 0x18.
- R10: When ack_en_i is low, a processor acknowledge is ignored: ack_valid_o stays low and ack_vec_o keeps its value.
- R11: Acknowledges have no side effect on the sources. Repeating a query with unchanged requests returns the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Active request lines, one per source |
| rd_en_i | input | 1 | Byte read strobe |
| rd_addr_i | input | ADDR_W | Byte offset within the window |
| rdata_o | output | 8 | Read data (vector number) |
| rvalid_o | output | 1 | Read data valid, one cycle |
| ack_en_i | input | 1 | Enables processor acknowledge cycles |
| cpu_ack_i | input | 1 | Processor acknowledge strobe |
| cpu_ack_lvl_i | input | 3 | Level carried by the acknowledge |
| ack_vec_o | output | 8 | Acknowledge vector |
| ack_valid_o | output | 1 | Acknowledge vector valid, one cycle |

## Verification
The lookup is first tried with no request lines active. This separates the spurious answer of level reads from the zero answer of software reads and from the zero of unmapped offsets. Hand-picked pairs of sources then check ordering. Two sources at one level test rank within a level. Sources at different levels test the level order of software reads. A source at the wrong level tests the level filter. Random request patterns, both sparse and dense, are then read at random offsets and through acknowledge cycles with the enable randomly on or off. Sparse patterns exercise the idle-level answers. Dense patterns stress the winner selection.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int unsigned NUM_LVL  = 7;
  localparam int unsigned VEC_W    = 8;
  localparam logic [7:0]  SPURIOUS = 8'h18;

  function automatic logic [2:0] src_level(int unsigned idx);
    return 3'((idx % NUM_LVL) + 1);
  endfunction
endpackage

// File: rtl/iack_level_pick.sv
module iack_level_pick
  import iack_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned VEC_BASE = 64,
  parameter logic [2:0]  LEVEL    = 3'd1
) (
  input  logic [N_SRC-1:0] irq_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] in_lvl;

  for (genvar g = 0; g < N_SRC; g++) begin : g_mask
    assign in_lvl[g] = (src_level(g) == LEVEL);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    vec_o = SPURIOUS;
    for (int i = 0; i < N_SRC; i++) begin
      if (irq_i[i] && in_lvl[i] && !hit_o) begin
        hit_o = 1'b1;
        vec_o = VEC_W'(VEC_BASE + i);
      end
    end
  end
endmodule

// File: rtl/iack_sw_pick.sv
module iack_sw_pick
  import iack_pkg::*;
(
  input  logic [NUM_LVL:1]            hit_i,
  input  logic [NUM_LVL:1][VEC_W-1:0] lvl_vec_i,
  output logic [VEC_W-1:0]            vec_o
);
  // highest level wins; zero when idle
  always_comb begin
    vec_o = '0;
    for (int l = 1; l <= NUM_LVL; l++) begin
      if (hit_i[l]) vec_o = lvl_vec_i[l];
    end
  end
endmodule

// File: rtl/iack_vector_unit.sv
module iack_vector_unit
  import iack_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  input  logic              ack_en_i,
  input  logic              cpu_ack_i,
  input  logic [2:0]        cpu_ack_lvl_i,
  output logic [7:0]        ack_vec_o,
  output logic              ack_valid_o
);
  localparam logic [ADDR_W-1:0] SW_OFFS = ADDR_W'(32'h20);

  logic [NUM_LVL:1]            lvl_hit;
  logic [NUM_LVL:1][VEC_W-1:0] lvl_vec;
  logic [VEC_W-1:0]            sw_vec;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    iack_level_pick #(
      .N_SRC   (N_SRC),
      .VEC_BASE(VEC_BASE),
      .LEVEL   (3'(l))
    ) i_pick (
      .irq_i(irq_i),
      .hit_o(lvl_hit[l]),
      .vec_o(lvl_vec[l])
    );
  end

  iack_sw_pick i_sw (
    .hit_i    (lvl_hit),
    .lvl_vec_i(lvl_vec),
    .vec_o    (sw_vec)
  );

  // window decode: 0x20 software, 0x24..0x3C levels 1..7
  logic             mapped;
  logic [2:0]       rd_sel;
  logic [VEC_W-1:0] rd_next;
  logic [VEC_W-1:0] ack_next;

  assign mapped = (rd_addr_i[ADDR_W-1:5] == '0 + 1'b1) && (rd_addr_i[1:0] == 2'b00);
  assign rd_sel = rd_addr_i[4:2];

  always_comb begin
    if (!mapped)          rd_next = '0;
    else if (rd_sel == 0) rd_next = sw_vec;
    else                  rd_next = lvl_vec[rd_sel];
  end

  always_comb begin
    if (cpu_ack_lvl_i == 3'd0) ack_next = SPURIOUS;
    else                       ack_next = lvl_vec[cpu_ack_lvl_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vec_o   <= '0;
      ack_valid_o <= 1'b0;
    end else begin
      ack_valid_o <= cpu_ack_i && ack_en_i;
      if (cpu_ack_i && ack_en_i) ack_vec_o <= ack_next;
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rvalid_o && $stable(rdata_o))); // R8
  AST_ACK_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_i && ack_en_i) |=> ack_valid_o); // R9
  AST_ACK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_ack_i && ack_en_i) |=> (!ack_valid_o && $stable(ack_vec_o))); // R10
  AST_SW_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == SW_OFFS && irq_i == '0) |=> (rdata_o == 8'h00)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !mapped) |=> (rdata_o == 8'h00)); // R7
  AST_IDLE_LVL_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_i && ack_en_i && cpu_ack_lvl_i != 0 && !lvl_hit[cpu_ack_lvl_i])
      |=> (ack_vec_o == SPURIOUS)); // R4
endmodule

// File: tb/test_iack_vector_unit.sv
module test_iack_vector_unit;
  localparam int unsigned N = 32;
  localparam time         PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic         rd_en_i = 1'b0;
  logic [7:0]   rd_addr_i = '0;
  logic [7:0]   rdata_o;
  logic         rvalid_o;
  logic         ack_en_i = 1'b0;
  logic         cpu_ack_i = 1'b0;
  logic [2:0]   cpu_ack_lvl_i = '0;
  logic [7:0]   ack_vec_o;
  logic         ack_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  iack_vector_unit i_iack_vector_unit (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] m_level(logic [N-1:0] q, int n);
    for (int i = 0; i < N; i++) if (q[i] && (i % 7) + 1 == n) return 8'(64 + i);
    return 8'h18;
  endfunction

  function automatic logic [7:0] m_sw(logic [N-1:0] q);
    for (int n = 7; n >= 1; n--) if (m_level(q, n) != 8'h18) return m_level(q, n);
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_read(logic [N-1:0] q, logic [7:0] a);
    if (a == 8'h20) return m_sw(q);
    if (a[7:5] == 3'd1 && a[1:0] == 2'b00) return m_level(q, int'(a[4:2]));
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk_i);
    rd_en_i = 1'b1;
    rd_addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
    v = rvalid_o;
  endtask

  task automatic do_ack(logic en, logic [2:0] lvl, output logic [7:0] d, output logic v);
    @(negedge clk_i);
    cpu_ack_i = 1'b1;
    ack_en_i = en;
    cpu_ack_lvl_i = lvl;
    @(negedge clk_i);
    cpu_ack_i = 1'b0;
    d = ack_vec_o;
    v = ack_valid_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2, prev;
    logic v;
    void'($urandom(32'd20240611));
    #(PERIOD * 3);
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 rvalid", 8'(rvalid_o), 8'h00);
    chk("R1 ack_vec", ack_vec_o, 8'h00);
    chk("R1 ack_valid", 8'(ack_valid_o), 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // idle requests
    do_read(8'h20, d, v); chk("R6 sw idle", d, 8'h00); chk("R8 rvalid", 8'(v), 8'h01);
    for (int n = 1; n <= 7; n++) begin
      do_read(8'(32 + 4 * n), d, v); chk("R4 idle level", d, 8'h18);
    end
    do_read(8'h00, d, v); chk("R7 off 0x00", d, 8'h00);
    irq_i = 32'h0000_0001;
    do_read(8'h21, d, v); chk("R7 off 0x21", d, 8'h00);
    do_read(8'h1C, d, v); chk("R7 off 0x1C", d, 8'h00);
    do_read(8'h40, d, v); chk("R7 off 0x40", d, 8'h00);
    do_read(8'hFF, d, v); chk("R7 off 0xFF", d, 8'h00);

    // ranking within and across levels
    irq_i = (32'd1 << 7) | (32'd1 << 0);
    do_read(8'h24, d, v); chk("R3 lowest index", d, 8'd64);
    irq_i = 32'd1 << 7;
    do_read(8'h24, d, v); chk("R2 src7 level1", d, 8'd71);
    do_read(8'h28, d, v); chk("R3 other level ignored", d, 8'h18);
    irq_i = (32'd1 << 6) | (32'd1 << 0) | (32'd1 << 13);
    do_read(8'h20, d, v); chk("R5 highest level", d, 8'd70);
    do_read(8'h3C, d, v); chk("R3 level7 rank", d, 8'd70);
    do_read(8'h20, d2, v); chk("R11 repeat", d2, d);

    // hold without read
    prev = rdata_o;
    irq_i = 32'd1 << 5;
    @(negedge clk_i);
    chk("R8 no read rvalid", 8'(rvalid_o), 8'h00);
    chk("R8 no read hold", rdata_o, prev);

    // processor acknowledge
    irq_i = 32'd1 << 7;
    do_ack(1'b1, 3'd1, d, v); chk("R9 ack vec", d, 8'd71); chk("R9 ack valid", 8'(v), 8'h01);
    do_ack(1'b1, 3'd0, d, v); chk("R9 level0", d, 8'h18);
    do_ack(1'b1, 3'd1, d, v);
    do_ack(1'b0, 3'd2, d2, v); chk("R10 vec held", d2, 8'd71); chk("R10 no valid", 8'(v), 8'h00);

    // random
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] q;
      logic [7:0] a;
      logic [2:0] l;
      logic en;
      q = (k % 2 == 0) ? ($urandom & $urandom & $urandom) : $urandom;
      irq_i = q;
      a = ($urandom % 3 == 0) ? 8'($urandom) : 8'(32 + 4 * ($urandom % 8));
      do_read(a, d, v);
      chk("R3/R5 random read", d, m_read(q, a));
      l = 3'($urandom);
      en = 1'($urandom);
      prev = ack_vec_o;
      do_ack(en, l, d, v);
      if (en) chk("R9 random ack", d, (l == 0) ? 8'h18 : m_level(q, int'(l)));
      else    chk("R10 random ack", d, prev);
    end
    finish_run();
  end
endmodule